// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block is a synchronous front end for the command pins of a two-bank SDRAM. On every rising clock edge it samples chip select, the three row/column/write strobes, clock enable, the address bus, the bank select bit and the data mask input. It turns each sampled cycle into a one-hot command strobe with the fields that belong to it. These fields are bank, row, column, the auto-precharge request and the precharge-all flag. Results are registered, so they appear one cycle after sampling.

Alongside decoding, the block keeps a small model of the device state. It records whether each bank is idle or holds an open row, and which row that is. It also holds the 12-bit mode word, tracks entry to and exit from self refresh, and closes a bank by itself when a burst with auto-precharge has run its length. A single-cycle error flag marks commands that are illegal in the current bank state. The data mask is passed on with no delay as a write-data block and with a two-period delay as a read-output high-impedance enable. A controller model, a protocol monitor or a memory model can use these outputs without decoding the pins itself.

Top module: `sdram_cmd_front`

## Requirements
- R1: With cs_n high the cycle decodes to no command. With cs_n low, {ras_n,cas_n,we_n} = 111 is no operation, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge, 001 refresh and 000 mode load. The matching strobe among act_o, rd_o, wr_o, bst_o, pre_o, aref_o, sref_o and lmr_o is high for the single period after the sampling edge, and at most one of these strobes is high at a time.
- R2: An activate to an idle bank (bank = ba, 0 or 1) opens that bank, stores addr[10:0] as its open row and drives bank_o and row_o. Bank b's row appears on open_row_o[b*11 +: 11] and its state on bank_open_o[b].
- R3: On read or write, col_o takes addr[8:0], ap_o takes addr[10] and bank_o takes ba.
- R4: On precharge, pre_all_o takes addr[10]. If addr[10] is 0 only bank ba is closed. If addr[10] is 1 both banks are closed and ba has no effect. Precharging an idle bank is not an error.
- R5: A legal read or write with addr[10] = 1 closes its bank BL edges after the sampling edge. BL = 2^mode[1:0] (1, 2, 4 or 8), and mode[2] does not affect it.
- R6: A legal mode load writes {ba, addr[10:0]} into mode_o, with ba in bit 11. mode_o changes only on a legal mode load.
- R7: err_o is high for one period after an illegal command and low otherwise. Illegal commands are a read or write to an idle bank, an activate to an open bank, and a refresh (with cke high or low) or a mode load while any bank is open. An illegal command still raises its strobe but does not change bank state, mode_o or self refresh.
- R8: Refresh with cke high raises aref_o. A refresh of either kind leaves bank_o, row_o, col_o, ap_o and pre_all_o unchanged.
- R9: Refresh sampled with cke low raises sref_o. If all banks are idle it also sets self_ref_o. While self_ref_o is high every command is ignored, with no strobe, no error and no state change. The first edge that samples cke high clears self_ref_o, and that cycle's command is also ignored. Outside self refresh, any command other than refresh sampled with cke low is ignored.
- R10: wr_mask_o equals dqm in the same period, with no register on the path. rd_hiz_o equals dqm delayed by exactly two clock periods.
- R11: While rst_n is low all strobes, err_o, self_ref_o, rd_hiz_o, mode_o and bank_open_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | 1 | Bank select |
| addr | input | 11 | Address bus (row, column, control bit 10, opcode) |
| dqm | input | 1 | Data mask |
| act_o | output | 1 | Activate strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| bst_o | output | 1 | Burst stop strobe |
| pre_o | output | 1 | Precharge strobe |
| aref_o | output | 1 | Auto refresh strobe |
| sref_o | output | 1 | Self refresh entry request strobe |
| lmr_o | output | 1 | Mode load strobe |
| bank_o | output | 1 | Bank of the last bank-addressed command |
| row_o | output | 11 | Row of the last activate |
| col_o | output | 9 | Column of the last read or write |
| ap_o | output | 1 | Auto-precharge request of the last read or write |
| pre_all_o | output | 1 | All-bank flag of the last precharge |
| mode_o | output | 12 | Mode word |
| err_o | output | 1 | Illegal command flag |
| bank_open_o | output | 2 | Per-bank open state |
| open_row_o | output | 22 | Per-bank open row, bank 0 in the low bits |
| self_ref_o | output | 1 | Device is in self refresh |
| wr_mask_o | output | 1 | Write data block, no delay |
| rd_hiz_o | output | 1 | Read output high-impedance enable, two periods late |

## Verification
Strobes, fields, err_o, mode_o, bank_open_o and self_ref_o all come from one register stage. The bench drives inputs on the falling edge, lets one rising edge pass and compares at the next falling edge. Auto-precharge closure is due BL edges after the command, so the bench checks bank_open_o one edge before that point, when it must still be high, and again at that point, when it must be low. wr_mask_o is compared shortly after dqm changes, before any edge. rd_hiz_o is compared after the sampling edge, one edge later and two edges later, and must be high only at the second of these.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_ACT,
    K_RD,
    K_WR,
    K_BST,
    K_PRE,
    K_REF,
    K_LMR
  } cmd_e;

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  input  logic in_sref,
  output cmd_e kind,
  output logic sref_req
);

  cmd_e raw;

  always_comb begin
    raw = K_NONE;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  raw = K_ACT;
        3'b101:  raw = K_RD;
        3'b100:  raw = K_WR;
        3'b110:  raw = K_BST;
        3'b010:  raw = K_PRE;
        3'b001:  raw = K_REF;
        3'b000:  raw = K_LMR;
        default: raw = K_NONE;
      endcase
    end
  end

  // Gating by clock enable and self refresh state
  always_comb begin
    kind     = K_NONE;
    sref_req = 1'b0;
    if (!in_sref) begin
      if (cke) begin
        kind = raw;
      end else if (raw == K_REF) begin
        sref_req = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank #(
  parameter int ROW_W = 11,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_req,
  input  logic             close_req,
  input  logic             ap_req,
  input  logic [CNT_W-1:0] ap_len,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q
);

  logic             open_q, open_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ROW_W-1:0] row_d;
  logic             row_en;

  always_comb begin
    open_d = open_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    row_en = 1'b0;
    row_d  = row_in;
    if (close_req) begin
      open_d = 1'b0;
      pend_d = 1'b0;
    end else if (open_req) begin
      open_d = 1'b1;
      pend_d = 1'b0;
      row_en = 1'b1;
    end else if (ap_req) begin
      pend_d = 1'b1;
      cnt_d  = ap_len;
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        open_d = 1'b0;
        pend_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      open_q <= open_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (row_en) begin
      row_q <= row_d;
    end
  end

  assign is_open = open_q;

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (open_req && !close_req) |=> (is_open && row_q == $past(row_in)));

  p_pre_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    close_req |=> !is_open);

  p_ap_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cnt_q == '0 && !close_req && !open_req && !ap_req) |=> !is_open);

endmodule

// File: rtl/sdcmd_dqm.sv
module sdcmd_dqm #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dqm,
  output logic wr_mask,
  output logic rd_hiz
);

  localparam int WARM_W = $clog2(LAT + 1);

  logic [LAT-1:0] pipe_q, pipe_d;

  generate
    if (LAT == 1) begin : g_single
      always_comb pipe_d = dqm;
    end else begin : g_chain
      always_comb pipe_d = {pipe_q[LAT-2:0], dqm};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign wr_mask = dqm;
  assign rd_hiz  = pipe_q[LAT-1];

  // Cycles since reset, saturating, so the delay check never reaches before reset
  logic [WARM_W-1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
    end else if (warm_q != WARM_W'(LAT)) begin
      warm_q <= warm_q + 1'b1;
    end
  end

  generate
    if (LAT <= 4) begin : g_chk
      p_rd_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == WARM_W'(LAT)) |-> (rd_hiz == $past(dqm, LAT)));
    end
  endgenerate

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdcmd_pkg::*;
#(
  parameter  int ADDR_W      = 11,
  parameter  int COL_W       = 9,
  parameter  int AP_BIT      = 10,
  parameter  int NBANK       = 2,
  parameter  int BL_CODE_W   = 2,
  parameter  int RD_MASK_LAT = 2,
  localparam int BA_W        = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int MODE_W      = ADDR_W + BA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic                    cke,
  input  logic [BA_W-1:0]         ba,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    dqm,
  output logic                    act_o,
  output logic                    rd_o,
  output logic                    wr_o,
  output logic                    bst_o,
  output logic                    pre_o,
  output logic                    aref_o,
  output logic                    sref_o,
  output logic                    lmr_o,
  output logic [BA_W-1:0]         bank_o,
  output logic [ADDR_W-1:0]       row_o,
  output logic [COL_W-1:0]        col_o,
  output logic                    ap_o,
  output logic                    pre_all_o,
  output logic [MODE_W-1:0]       mode_o,
  output logic                    err_o,
  output logic [NBANK-1:0]        bank_open_o,
  output logic [NBANK*ADDR_W-1:0] open_row_o,
  output logic                    self_ref_o,
  output logic                    wr_mask_o,
  output logic                    rd_hiz_o
);

  localparam int CNT_W = (2 ** BL_CODE_W) - 1;
  localparam int NSTB  = 8;

  cmd_e kind;
  logic sref_req;
  logic sref_q, sref_d;

  sdcmd_decode u_dec (
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .cke      (cke),
    .in_sref  (sref_q),
    .kind     (kind),
    .sref_req (sref_req)
  );

  // Legality against current bank state
  logic [NBANK-1:0] open_v;
  logic             sel_open, any_open, err_d, legal;

  assign sel_open = open_v[ba];
  assign any_open = |open_v;

  always_comb begin
    err_d = 1'b0;
    unique case (kind)
      K_ACT:       err_d = sel_open;
      K_RD, K_WR:  err_d = !sel_open;
      K_REF,K_LMR: err_d = any_open;
      default:     err_d = 1'b0;
    endcase
    if (sref_req && any_open) err_d = 1'b1;
  end
  assign legal = !err_d;

  // Self refresh state
  always_comb begin
    if (sref_q) sref_d = !cke;
    else        sref_d = sref_req && legal;
  end

  // Strobes, next value
  logic [NSTB-1:0] stb_d, stb_q;
  always_comb begin
    stb_d    = '0;
    stb_d[7] = (kind == K_ACT);
    stb_d[6] = (kind == K_RD);
    stb_d[5] = (kind == K_WR);
    stb_d[4] = (kind == K_BST);
    stb_d[3] = (kind == K_PRE);
    stb_d[2] = (kind == K_REF);
    stb_d[1] = sref_req;
    stb_d[0] = (kind == K_LMR);
  end

  // Field capture enables
  logic bank_en, row_en, col_en, pre_en, mode_en;
  assign bank_en = (kind == K_ACT) || (kind == K_RD) || (kind == K_WR) || (kind == K_PRE);
  assign row_en  = (kind == K_ACT);
  assign col_en  = (kind == K_RD) || (kind == K_WR);
  assign pre_en  = (kind == K_PRE);
  assign mode_en = (kind == K_LMR) && legal;

  logic [BA_W-1:0]   bank_q;
  logic [ADDR_W-1:0] row_q;
  logic [COL_W-1:0]  col_q;
  logic              ap_q, pall_q, err_q;
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= '0;
      err_q  <= 1'b0;
      sref_q <= 1'b0;
    end else begin
      stb_q  <= stb_d;
      err_q  <= err_d;
      sref_q <= sref_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      ap_q   <= 1'b0;
      pall_q <= 1'b0;
      mode_q <= '0;
    end else begin
      if (bank_en) bank_q <= ba;
      if (row_en)  row_q  <= addr;
      if (col_en) begin
        col_q <= addr[COL_W-1:0];
        ap_q  <= addr[AP_BIT];
      end
      if (pre_en)  pall_q <= addr[AP_BIT];
      if (mode_en) mode_q <= {ba, addr};
    end
  end

  // Auto-precharge length from the mode word: BL - 1
  logic [CNT_W:0]   bl_full;
  logic [CNT_W-1:0] ap_len;
  assign bl_full = (CNT_W+1)'(1) << mode_q[BL_CODE_W-1:0];
  assign ap_len  = CNT_W'(bl_full - (CNT_W+1)'(1));

  generate
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
      logic sel, open_req, close_req, ap_req;
      assign sel       = (ba == BA_W'(g));
      assign open_req  = (kind == K_ACT) && sel && legal;
      assign close_req = (kind == K_PRE) && (addr[AP_BIT] || sel);
      assign ap_req    = ((kind == K_RD) || (kind == K_WR)) && sel && legal && addr[AP_BIT];

      sdcmd_bank #(
        .ROW_W (ADDR_W),
        .CNT_W (CNT_W)
      ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_req  (open_req),
        .close_req (close_req),
        .ap_req    (ap_req),
        .ap_len    (ap_len),
        .row_in    (addr),
        .is_open   (open_v[g]),
        .row_q     (open_row_o[g*ADDR_W +: ADDR_W])
      );
    end
  endgenerate

  sdcmd_dqm #(
    .LAT (RD_MASK_LAT)
  ) u_dqm (
    .clk     (clk),
    .rst_n   (rst_n),
    .dqm     (dqm),
    .wr_mask (wr_mask_o),
    .rd_hiz  (rd_hiz_o)
  );

  assign {act_o, rd_o, wr_o, bst_o, pre_o, aref_o, sref_o, lmr_o} = stb_q;
  assign bank_o      = bank_q;
  assign row_o       = row_q;
  assign col_o       = col_q;
  assign ap_o        = ap_q;
  assign pre_all_o   = pall_q;
  assign mode_o      = mode_q;
  assign err_o       = err_q;
  assign bank_open_o = open_v;
  assign self_ref_o  = sref_q;

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_o, rd_o, wr_o, bst_o, pre_o, aref_o, sref_o, lmr_o}));

  p_sref_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    self_ref_o |=> (!act_o && !rd_o && !wr_o && !pre_o && !lmr_o && !err_o && $stable(bank_open_o)));

  p_mode_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_LMR && any_open) |=> $stable(mode_o));

  p_err_keeps_banks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == K_ACT || kind == K_RD || kind == K_WR) && err_d) |=> $stable(bank_open_o));

endmodule

// File: tb/sim_sdram_cmd_front.sv
module sim_sdram_cmd_front;

  localparam int CLK_P = 10;

  localparam logic [3:0] OP_NOP = 4'd0, OP_ACT = 4'd1, OP_RD = 4'd2, OP_WR = 4'd3,
                         OP_BST = 4'd4, OP_PRE = 4'd5, OP_REF = 4'd6, OP_LMR = 4'd7,
                         OP_INH = 4'd8;

  localparam logic [7:0] S_NONE = 8'h00, S_ACT = 8'h80, S_RD = 8'h40, S_WR = 8'h20,
                         S_BST = 8'h10, S_PRE = 8'h08, S_AREF = 8'h04, S_SREF = 8'h02,
                         S_LMR = 8'h01;

  typedef struct packed {
    logic [3:0]  op;
    logic        cke;
    logic        ba;
    logic [10:0] addr;
    logic [7:0]  exp_s;
    logic        exp_e;
    logic [1:0]  exp_o;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{OP_NOP, 1'b1, 1'b0, 11'h000, S_NONE, 1'b0, 2'b00},  // R1 nop
    '{OP_INH, 1'b1, 1'b0, 11'h7FF, S_NONE, 1'b0, 2'b00},  // R1 inhibit
    '{OP_ACT, 1'b1, 1'b0, 11'h155, S_ACT,  1'b0, 2'b01},  // R2
    '{OP_ACT, 1'b1, 1'b0, 11'h0AA, S_ACT,  1'b1, 2'b01},  // R7 act to open
    '{OP_RD,  1'b1, 1'b1, 11'h010, S_RD,   1'b1, 2'b01},  // R7 read idle
    '{OP_ACT, 1'b1, 1'b1, 11'h2AA, S_ACT,  1'b0, 2'b11},  // R2
    '{OP_WR,  1'b1, 1'b1, 11'h1F3, S_WR,   1'b0, 2'b11},  // R3
    '{OP_BST, 1'b1, 1'b0, 11'h000, S_BST,  1'b0, 2'b11},  // R1
    '{OP_REF, 1'b1, 1'b0, 11'h000, S_AREF, 1'b1, 2'b11},  // R7 refresh open
    '{OP_LMR, 1'b1, 1'b0, 11'h7FF, S_LMR,  1'b1, 2'b11},  // R7 mode open
    '{OP_PRE, 1'b1, 1'b0, 11'h000, S_PRE,  1'b0, 2'b10},  // R4 single
    '{OP_PRE, 1'b1, 1'b0, 11'h400, S_PRE,  1'b0, 2'b00},  // R4 all
    '{OP_REF, 1'b1, 1'b0, 11'h000, S_AREF, 1'b0, 2'b00},  // R8
    '{OP_LMR, 1'b1, 1'b0, 11'h003, S_LMR,  1'b0, 2'b00},  // R6
    '{OP_RD,  1'b1, 1'b0, 11'h000, S_RD,   1'b1, 2'b00},  // R7
    '{OP_ACT, 1'b0, 1'b0, 11'h000, S_NONE, 1'b0, 2'b00}   // R9 cke low
  };

  logic        clk, rst_n, cs_n, ras_n, cas_n, we_n, cke, ba, dqm;
  logic [10:0] addr;
  logic        act_o, rd_o, wr_o, bst_o, pre_o, aref_o, sref_o, lmr_o;
  logic        bank_o, ap_o, pre_all_o, err_o, self_ref_o, wr_mask_o, rd_hiz_o;
  logic [10:0] row_o;
  logic [8:0]  col_o;
  logic [11:0] mode_o;
  logic [1:0]  bank_open_o;
  logic [21:0] open_row_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sdram_cmd_front u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .ba(ba), .addr(addr), .dqm(dqm),
    .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .bst_o(bst_o), .pre_o(pre_o),
    .aref_o(aref_o), .sref_o(sref_o), .lmr_o(lmr_o), .bank_o(bank_o), .row_o(row_o),
    .col_o(col_o), .ap_o(ap_o), .pre_all_o(pre_all_o), .mode_o(mode_o), .err_o(err_o),
    .bank_open_o(bank_open_o), .open_row_o(open_row_o), .self_ref_o(self_ref_o),
    .wr_mask_o(wr_mask_o), .rd_hiz_o(rd_hiz_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] stb();
    return {act_o, rd_o, wr_o, bst_o, pre_o, aref_o, sref_o, lmr_o};
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_pins(input logic [3:0] op, input logic c, input logic b, input logic [10:0] a);
    cke  = c;
    ba   = b;
    addr = a;
    cs_n = 1'b0;
    case (op)
      OP_NOP:  {ras_n, cas_n, we_n} = 3'b111;
      OP_ACT:  {ras_n, cas_n, we_n} = 3'b011;
      OP_RD:   {ras_n, cas_n, we_n} = 3'b101;
      OP_WR:   {ras_n, cas_n, we_n} = 3'b100;
      OP_BST:  {ras_n, cas_n, we_n} = 3'b110;
      OP_PRE:  {ras_n, cas_n, we_n} = 3'b010;
      OP_REF:  {ras_n, cas_n, we_n} = 3'b001;
      OP_LMR:  {ras_n, cas_n, we_n} = 3'b000;
      default: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b000; end
    endcase
  endtask

  // Drive at a falling edge, pass one rising edge, return at the next falling edge
  task automatic step(input logic [3:0] op, input logic c, input logic b, input logic [10:0] a);
    set_pins(op, c, b, a);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    dqm   = 1'b0;
    set_pins(OP_INH, 1'b1, 1'b0, 11'h000);
    repeat (3) @(negedge clk);

    // R11: reset state
    check(stb() == 8'h00, "R11", "strobes in reset", stb(), 0);
    check(err_o == 1'b0 && self_ref_o == 1'b0 && rd_hiz_o == 1'b0, "R11", "flags in reset",
          {err_o, self_ref_o, rd_hiz_o}, 0);
    check(mode_o == 12'h000 && bank_open_o == 2'b00, "R11", "mode and banks in reset",
          {mode_o, bank_open_o}, 0);
    rst_n = 1'b1;

    // Table walk: R1, R2, R3, R4, R7, R8, R9
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].op, VEC[i].cke, VEC[i].ba, VEC[i].addr);
      check(stb() == VEC[i].exp_s, "R1", $sformatf("vector %0d strobe", i), stb(), VEC[i].exp_s);
      check(err_o == VEC[i].exp_e, "R7", $sformatf("vector %0d error", i), err_o, VEC[i].exp_e);
      check(bank_open_o == VEC[i].exp_o, "R2", $sformatf("vector %0d banks", i),
            bank_open_o, VEC[i].exp_o);
    end
    check(mode_o == 12'h003, "R6", "mode after table (R7 illegal load kept out)", mode_o, 12'h003);

    // R6: bank bit lands in bit 11
    step(OP_LMR, 1'b1, 1'b1, 11'h456);
    check(mode_o == 12'hC56, "R6", "mode word", mode_o, 12'hC56);

    // R2 and R3 fields, R5 with BL 4
    step(OP_ACT, 1'b1, 1'b0, 11'h3C5);
    check(row_o == 11'h3C5 && bank_o == 1'b0, "R2", "row and bank", {bank_o, row_o}, 12'h3C5);
    check(open_row_o[10:0] == 11'h3C5, "R2", "open row bank0", open_row_o[10:0], 11'h3C5);
    step(OP_WR, 1'b1, 1'b0, 11'h5A7);
    check(col_o == 9'h1A7 && ap_o == 1'b1, "R3", "column and auto-precharge", {ap_o, col_o}, 10'h3A7);
    step(OP_NOP, 1'b1, 1'b0, 11'h000);
    step(OP_NOP, 1'b1, 1'b0, 11'h000);
    step(OP_NOP, 1'b1, 1'b0, 11'h000);
    check(bank_open_o == 2'b01, "R5", "bank open at BL-1", bank_open_o, 2'b01);
    step(OP_NOP, 1'b1, 1'b0, 11'h000);
    check(bank_open_o == 2'b00, "R5", "bank closed at BL 4", bank_open_o, 2'b00);

    // R8: refresh leaves fields alone
    step(OP_REF, 1'b1, 1'b1, 11'h0FF);
    check(aref_o == 1'b1 && err_o == 1'b0, "R8", "auto refresh strobe", {aref_o, err_o}, 2'b10);
    check(col_o == 9'h1A7 && bank_o == 1'b0 && row_o == 11'h3C5, "R8", "fields held",
          {bank_o, col_o}, 10'h1A7);

    // R5 with BL 2 on bank 1, mode bit 2 set and ignored
    step(OP_LMR, 1'b1, 1'b0, 11'h005);
    step(OP_ACT, 1'b1, 1'b1, 11'h011);
    step(OP_RD, 1'b1, 1'b1, 11'h400);
    check(bank_open_o == 2'b10, "R5", "bank1 open after read", bank_open_o, 2'b10);
    step(OP_NOP, 1'b1, 1'b0, 11'h000);
    check(bank_open_o == 2'b10, "R5", "bank1 open at BL-1", bank_open_o, 2'b10);
    step(OP_NOP, 1'b1, 1'b0, 11'h000);
    check(bank_open_o == 2'b00, "R5", "bank1 closed at BL 2", bank_open_o, 2'b00);

    // R4: precharge all and single-bank selection
    step(OP_ACT, 1'b1, 1'b0, 11'h001);
    step(OP_ACT, 1'b1, 1'b1, 11'h002);
    step(OP_PRE, 1'b1, 1'b1, 11'h400);
    check(bank_open_o == 2'b00 && pre_all_o == 1'b1, "R4", "precharge all",
          {pre_all_o, bank_open_o}, 3'b100);
    step(OP_ACT, 1'b1, 1'b0, 11'h001);
    step(OP_PRE, 1'b1, 1'b1, 11'h000);
    check(bank_open_o == 2'b01 && pre_all_o == 1'b0 && err_o == 1'b0, "R4",
          "precharge idle bank1 only", {pre_all_o, bank_open_o}, 3'b001);

    // R7: illegal load and illegal self refresh entry keep state
    step(OP_LMR, 1'b1, 1'b0, 11'h0F0);
    check(err_o == 1'b1 && mode_o == 12'h005, "R7", "illegal load", {err_o, mode_o}, 13'h1005);
    step(OP_REF, 1'b0, 1'b0, 11'h000);
    check(err_o == 1'b1 && sref_o == 1'b1 && self_ref_o == 1'b0, "R7", "self refresh refused",
          {err_o, sref_o, self_ref_o}, 3'b110);
    step(OP_PRE, 1'b1, 1'b0, 11'h400);

    // R9: self refresh entry, ignore, exit
    step(OP_REF, 1'b0, 1'b0, 11'h000);
    check(sref_o == 1'b1 && self_ref_o == 1'b1 && err_o == 1'b0, "R9", "self refresh entry",
          {sref_o, self_ref_o, err_o}, 3'b110);
    step(OP_ACT, 1'b0, 1'b0, 11'h000);
    check(stb() == 8'h00 && self_ref_o == 1'b1 && bank_open_o == 2'b00, "R9",
          "ignored in self refresh", {stb(), self_ref_o}, 9'h001);
    step(OP_ACT, 1'b1, 1'b0, 11'h000);
    check(stb() == 8'h00 && self_ref_o == 1'b0 && bank_open_o == 2'b00, "R9",
          "exit cycle ignored", {stb(), self_ref_o, bank_open_o}, 0);
    step(OP_ACT, 1'b1, 1'b0, 11'h000);
    check(act_o == 1'b1 && bank_open_o == 2'b01, "R9", "command after exit",
          {act_o, bank_open_o}, 3'b101);
    step(OP_PRE, 1'b1, 1'b0, 11'h400);

    // R10: data mask delays
    set_pins(OP_NOP, 1'b1, 1'b0, 11'h000);
    dqm = 1'b1;
    #1;
    check(wr_mask_o == 1'b1, "R10", "write mask same period", wr_mask_o, 1);
    @(posedge clk);
    @(negedge clk);
    check(rd_hiz_o == 1'b0, "R10", "read hi-z not after one edge", rd_hiz_o, 0);
    dqm = 1'b0;
    #1;
    check(wr_mask_o == 1'b0, "R10", "write mask released", wr_mask_o, 0);
    @(posedge clk);
    @(negedge clk);
    check(rd_hiz_o == 1'b1, "R10", "read hi-z two periods late", rd_hiz_o, 1);
    @(posedge clk);
    @(negedge clk);
    check(rd_hiz_o == 1'b0, "R10", "read hi-z one period wide", rd_hiz_o, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule